// File: doc/BRIEF.md
# Keyboard Controller Host Mailbox

This block is a byte mailbox between a host I/O port pair and an embedded controller (EC), in the manner of a legacy keyboard controller. The host sees two ports. Port 0h takes host bytes on writes and gives the EC's outgoing byte on reads. Port 4h takes command bytes on writes and returns a status byte on reads. The EC sees a small register window in a 32-bit address space. In that window it reads the host's byte, writes its own byte for the host, reads the same status byte, and sets an enable bit.

Three flags form the handshake:
- input-full marks a host byte that the EC has not yet taken;
- output-full marks an EC byte that the host has not yet read;
- a command/data flag records which host port carried the last byte.

While the enable bit is clear, the host side is shut off. The EC side stays live, so firmware can set up the outgoing byte and then turn the interface on.

Top module: `kbc_mailbox`

## Requirements
- R1: After reset the enable bit, input-full, output-full and command/data are all 0, the incoming byte and the outgoing byte are 00h, and a host read at any offset returns FFh.
- R2: While the enable bit is 0, host writes change no state and host reads return FFh. A host read at 0h in that state leaves output-full set.
- R3: With the interface enabled, a host write at 0h loads the incoming byte, sets input-full and clears command/data. The status byte places output-full at bit 0, input-full at bit 1 and command/data at bit 3. All other bits read 0.
- R4: With the interface enabled, a host write at 4h loads the incoming byte, sets input-full and sets command/data.
- R5: An EC read at window offset 00h returns the incoming byte in bits 7:0 and clears input-full. Command/data keeps its value.
- R6: An EC write at window offset 00h loads the outgoing byte and sets output-full. A host read at 0h returns that byte and clears output-full.
- R7: A host read at 4h returns the status byte and changes no flag. An EC read at window offset 04h returns the same status byte.
- R8: The enable bit sits at bit 0 of window offset 08h and can be written and read back there. Bits 31:1 of that read are 0.
- R9: When a host write and an EC read of the incoming byte fall in the same cycle, input-full stays set and the new byte is kept. The EC read returns the byte that was held before.
- R10: When an EC write of the outgoing byte and a host read at 0h fall in the same cycle, the host gets the old byte, and output-full stays set with the new byte.
- R11: A host access at an offset other than 0h and 4h changes no state and reads return FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_addr | input | HOST_AW | Host port offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, combinational |
| ec_wr | input | 1 | EC write strobe |
| ec_rd | input | 1 | EC read strobe |
| ec_addr | input | EC_AW | EC byte address |
| ec_wdata | input | 8 | EC write byte |
| ec_rdata | output | 32 | EC read word, zero-extended, combinational |

## Verification
The bench builds the block with its default parameters:
- HOST_AW is 3, so offsets 0h, 4h and the unmapped offset 2h can all be reached.
- EC_AW is 32 and EC_BASE is 0000_2000h, so the EC window offset is worked out from full 32-bit addresses.

With these values the bench drives both same-cycle collisions, a host access while the interface is disabled, and a disable after use.

// File: rtl/kbc_mailbox.sv
module kbc_mailbox #(
  parameter int          HOST_AW = 3,
  parameter int          EC_AW   = 32,
  parameter logic [31:0] EC_BASE = 32'h0000_2000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [7:0]         host_wdata,
  output logic [7:0]         host_rdata,
  input  logic               ec_wr,
  input  logic               ec_rd,
  input  logic [EC_AW-1:0]   ec_addr,
  input  logic [7:0]         ec_wdata,
  output logic [31:0]        ec_rdata
);
  localparam logic [EC_AW-1:0] OFF_DATA = EC_AW'(8'h00);
  localparam logic [EC_AW-1:0] OFF_STAT = EC_AW'(8'h04);
  localparam logic [EC_AW-1:0] OFF_ACT  = EC_AW'(8'h08);

  logic [7:0] in_byte, out_byte;
  logic       ibf, obf, cmd_flag, active;

  logic host_dsel, host_csel;
  logic h_wr_d, h_wr_c, h_rd_d;
  logic [EC_AW-1:0] ec_off;
  logic e_rd_d, e_wr_d, e_rd_a, e_wr_a, e_rd_s;
  logic [7:0] status;

  assign host_dsel = (host_addr == HOST_AW'(0));
  assign host_csel = (host_addr == HOST_AW'(4));
  assign h_wr_d    = active & host_wr & host_dsel;
  assign h_wr_c    = active & host_wr & host_csel;
  assign h_rd_d    = active & host_rd & host_dsel;

  assign ec_off = ec_addr - EC_BASE[EC_AW-1:0];
  assign e_rd_d = ec_rd & (ec_off == OFF_DATA);
  assign e_wr_d = ec_wr & (ec_off == OFF_DATA);
  assign e_rd_s = ec_rd & (ec_off == OFF_STAT);
  assign e_rd_a = ec_rd & (ec_off == OFF_ACT);
  assign e_wr_a = ec_wr & (ec_off == OFF_ACT);

  assign status = {4'b0000, cmd_flag, 1'b0, ibf, obf};

  assign host_rdata = !active  ? 8'hFF :
                      host_dsel ? out_byte :
                      host_csel ? status : 8'hFF;

  assign ec_rdata = e_rd_d ? {24'd0, in_byte} :
                    e_rd_s ? {24'd0, status}  :
                    e_rd_a ? {31'd0, active}  : 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_byte  <= 8'h00;
      out_byte <= 8'h00;
      ibf      <= 1'b0;
      obf      <= 1'b0;
      cmd_flag <= 1'b0;
      active   <= 1'b0;
    end else begin
      if (h_wr_d || h_wr_c) begin
        in_byte  <= host_wdata;
        ibf      <= 1'b1;
        cmd_flag <= h_wr_c;
      end else if (e_rd_d) begin
        ibf <= 1'b0;
      end
      if (e_wr_d) begin
        out_byte <= ec_wdata;
        obf      <= 1'b1;
      end else if (h_rd_d) begin
        obf <= 1'b0;
      end
      if (e_wr_a) active <= ec_wdata[0];
    end
  end
endmodule

// File: rtl/kbc_mailbox_chk.sv
module kbc_mailbox_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_wr,
  input logic        host_rd,
  input logic [7:0]  host_rdata,
  input logic [31:0] ec_rdata,
  input logic        active,
  input logic        ibf,
  input logic        obf,
  input logic        cmd_flag,
  input logic [7:0]  in_byte,
  input logic        h_wr_d,
  input logic        h_wr_c,
  input logic        h_rd_d,
  input logic        e_rd_d,
  input logic        e_wr_d,
  input logic        e_rd_a
);
  // R3
  data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_wr_d |=> ibf && !cmd_flag);
  // R4
  cmd_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_wr_c |=> ibf && cmd_flag);
  // R5
  ec_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    e_rd_d && !h_wr_d && !h_wr_c |=> !ibf);
  // R9
  in_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr_d || h_wr_c) && e_rd_d |=> ibf);
  // R6
  ec_give_chk: assert property (@(posedge clk) disable iff (!rst_n)
    e_wr_d |=> obf);
  // R6
  host_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_rd_d && !e_wr_d |=> !obf);
  // R2
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active && host_rd |-> host_rdata == 8'hFF);
  // R2
  idle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active && host_wr && !e_rd_d |=> $stable(ibf) && $stable(in_byte) && $stable(cmd_flag));
  // R8
  act_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    e_rd_a |-> ec_rdata[31:1] == 31'd0);
endmodule

bind kbc_mailbox kbc_mailbox_chk chk_i (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
  .host_rdata(host_rdata), .ec_rdata(ec_rdata), .active(active),
  .ibf(ibf), .obf(obf), .cmd_flag(cmd_flag), .in_byte(in_byte),
  .h_wr_d(h_wr_d), .h_wr_c(h_wr_c), .h_rd_d(h_rd_d),
  .e_rd_d(e_rd_d), .e_wr_d(e_wr_d), .e_rd_a(e_rd_a)
);

// File: tb/kbc_mailbox_tb_top.sv
module kbc_mailbox_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0000_2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 0, host_rd = 0;
  logic [2:0]  host_addr = 0;
  logic [7:0]  host_wdata = 0;
  logic [7:0]  host_rdata;
  logic        ec_wr = 0, ec_rd = 0;
  logic [31:0] ec_addr = BASE;
  logic [7:0]  ec_wdata = 0;
  logic [31:0] ec_rdata;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kbc_mailbox dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ec_wr(ec_wr), .ec_rd(ec_rd), .ec_addr(ec_addr),
    .ec_wdata(ec_wdata), .ec_rdata(ec_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic h_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic h_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); host_rd = 1; host_addr = a; #1 d = host_rdata;
    @(negedge clk); host_rd = 0;
  endtask

  task automatic e_write(input logic [7:0] off, input logic [7:0] d);
    @(negedge clk); ec_wr = 1; ec_addr = BASE + 32'(off); ec_wdata = d;
    @(negedge clk); ec_wr = 0;
  endtask

  task automatic e_read(input logic [7:0] off, output logic [31:0] d);
    @(negedge clk); ec_rd = 1; ec_addr = BASE + 32'(off); #1 d = ec_rdata;
    @(negedge clk); ec_rd = 0;
  endtask

  task automatic t_reset();
    logic [31:0] w; logic [7:0] b;
    e_read(8'h04, w); chk("R1 status after reset", w, 32'h0);
    e_read(8'h08, w); chk("R1 enable after reset", w, 32'h0);
    e_read(8'h00, w); chk("R1 incoming byte after reset", w, 32'h0);
    h_read(3'd4, b);  chk("R1 host read disabled", 32'(b), 32'hFF);
  endtask

  task automatic t_inactive();
    logic [31:0] w; logic [7:0] b;
    h_write(3'd0, 8'h55);
    h_write(3'd4, 8'h66);
    e_read(8'h04, w); chk("R2 write ignored status", w, 32'h0);
    e_read(8'h00, w); chk("R2 write ignored byte", w, 32'h0);
    e_write(8'h00, 8'hAA);
    h_read(3'd0, b);  chk("R2 read returns FF", 32'(b), 32'hFF);
    e_read(8'h04, w); chk("R2 output-full kept", w, 32'h01);
  endtask

  task automatic t_enable();
    logic [31:0] w;
    e_write(8'h08, 8'hFF);
    e_read(8'h08, w); chk("R8 enable readback", w, 32'h1);
  endtask

  task automatic t_data_write();
    logic [31:0] w; logic [7:0] b;
    h_write(3'd0, 8'h3C);
    h_read(3'd4, b); chk("R3 status after data write", 32'(b), 32'h03);
    h_read(3'd4, b); chk("R7 status read no side effect", 32'(b), 32'h03);
    e_read(8'h04, w); chk("R7 EC status mirror", w, 32'h03);
    e_read(8'h00, w); chk("R5 EC reads byte", w, 32'h3C);
    e_read(8'h04, w); chk("R5 input-full cleared", w, 32'h01);
  endtask

  task automatic t_outgoing();
    logic [7:0] b;
    h_read(3'd0, b); chk("R6 host gets EC byte", 32'(b), 32'hAA);
    h_read(3'd4, b); chk("R6 output-full cleared", 32'(b), 32'h00);
  endtask

  task automatic t_cmd_write();
    logic [31:0] w; logic [7:0] b;
    h_write(3'd4, 8'hD1);
    h_read(3'd4, b); chk("R4 status after command write", 32'(b), 32'h0A);
    e_read(8'h00, w); chk("R4 command byte", w, 32'hD1);
    h_read(3'd4, b); chk("R5 command flag kept", 32'(b), 32'h08);
  endtask

  task automatic t_collide_in();
    logic [31:0] w; logic [7:0] b;
    h_write(3'd4, 8'h77);
    @(negedge clk);
    host_wr = 1; host_addr = 3'd0; host_wdata = 8'h22;
    ec_rd = 1; ec_addr = BASE; #1 w = ec_rdata;
    @(negedge clk); host_wr = 0; ec_rd = 0;
    chk("R9 EC got old byte", w, 32'h77);
    h_read(3'd4, b); chk("R9 input-full kept", 32'(b), 32'h02);
    e_read(8'h00, w); chk("R9 new byte kept", w, 32'h22);
  endtask

  task automatic t_collide_out();
    logic [7:0] b;
    e_write(8'h00, 8'h40);
    @(negedge clk);
    ec_wr = 1; ec_addr = BASE; ec_wdata = 8'h41;
    host_rd = 1; host_addr = 3'd0; #1 b = host_rdata;
    @(negedge clk); ec_wr = 0; host_rd = 0;
    chk("R10 host got old byte", 32'(b), 32'h40);
    h_read(3'd4, b); chk("R10 output-full kept", 32'(b), 32'h01);
    h_read(3'd0, b); chk("R10 new byte kept", 32'(b), 32'h41);
  endtask

  task automatic t_unmapped();
    logic [7:0] b;
    h_write(3'd2, 8'h99);
    h_read(3'd4, b); chk("R11 unmapped write ignored", 32'(b), 32'h00);
    h_read(3'd2, b); chk("R11 unmapped read FF", 32'(b), 32'hFF);
  endtask

  task automatic t_disable();
    logic [7:0] b;
    e_write(8'h08, 8'h00);
    h_read(3'd4, b); chk("R2 disabled after use", 32'(b), 32'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_inactive();
    t_enable();
    t_data_write();
    t_outgoing();
    t_cmd_write();
    t_collide_in();
    t_collide_out();
    t_unmapped();
    t_disable();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule